// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides a fast input clock by an integer ratio set by three configuration values: a prescaler base `N`, a program length `P` and a swallow count `S`. A small prescaler divides the input clock by `N` or `N+1`. Two event counters count the prescaler's output ticks. The swallow counter holds the prescaler at `N+1` for the first `S` ticks of every output period. The program counter ends the period after `P` ticks. One output period therefore spans `(N+1)*S + N*(P-S) = N*P + S` input clocks, so consecutive settings of `S` step the ratio by one input clock.

The block sits in the input clock domain. `div_pulse` goes high for one input clock at the end of each output period. The configuration pins are plain control inputs with no handshake. The block samples them into shadow registers while reset is held, and again only at the end of each output period. A change made part-way through a period therefore takes effect at the next period boundary and never produces a period of mixed length.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rst` is high, `div_pulse` is 0. The configuration pins are captured on every clock edge during reset.
- R2: For `N >= 2`, `P >= 1` and `S < P`, consecutive rising edges of `div_pulse` are exactly `N*P + S` input clocks apart.
- R3: After `rst` is sampled low, `div_pulse` is first seen high right after the `(N*P + S)`-th rising clock edge.
- R4: Each `div_pulse` lasts exactly one input clock when `N >= 2`.
- R5: Every output period starts with the prescaler in divide-by-`N+1` mode, unless `S = 0`. With `S = 0` every prescaler tick lasts `N` clocks and the period is `N*P`.
- R6: The configuration pins are sampled only on the edge that ends an output period. A change at any other time alters the next full period only, and the current period keeps its old length.
- R7: If `S >= P`, every prescaler tick in the period uses `N+1`, and the period is `(N+1)*P` input clocks.
- R8: The prescaler's internal count always stays below its current modulus.
- R9: The swallow count never exceeds the active `S`. It returns to 0 on the edge that ends a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset; also loads the configuration |
| cfg_n | input | NW | Prescaler base modulus N (N >= 2) |
| cfg_p | input | PW | Prescaler ticks per output period, P (P >= 1) |
| cfg_s | input | SW | Ticks at modulus N+1 per period, S |
| div_pulse | output | 1 | One-clock pulse marking the end of each output period |

## Verification
Two events can fall on the same prescaler tick: the swallow counter reaching `S`, and the program counter wrapping at `P`. When they coincide, the clear from the period end must win over the saturating increment. The bench provokes this with `S = P` and `S > P`, and judges it by checking that the measured period equals `(N+1)*P`. A second coincidence is the period end together with a new configuration on the pins. The bench changes the pins in the cycle right after a pulse and again in the middle of a period, and checks that exactly one more period has the old length.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Prescaler modulus selection
  typedef enum logic {
    PS_DIV_N  = 1'b0,
    PS_DIV_N1 = 1'b1
  } ps_mode_e;

endpackage

// File: rtl/psd_cfg_hold.sv
module psd_cfg_hold #(
  parameter int NW = 4,
  parameter int PW = 6,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NW-1:0] n_in,
  input  logic [PW-1:0] p_in,
  input  logic [SW-1:0] s_in,
  output logic [NW-1:0] n_q,
  output logic [PW-1:0] p_q,
  output logic [SW-1:0] s_q
);

  // Shadow copy: refreshed during reset and at each period boundary only
  always_ff @(posedge clk) begin
    if (rst || load) begin
      n_q <= n_in;
      p_q <= p_in;
      s_q <= s_in;
    end
  end

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(n_q) && $stable(p_q) && $stable(s_q)));

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] div_n,
  input  ps_mode_e      mode,
  output logic          tick
);

  localparam int CW = NW + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] modulus;
  logic [CW-1:0] last;

  assign modulus = {1'b0, div_n} + CW'(mode == PS_DIV_N1);
  assign last    = modulus - CW'(1);
  assign tick    = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  // R8
  presc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (div_n != '0) |-> (cnt < modulus));

endmodule

// File: rtl/psd_event_ctr.sv
module psd_event_ctr #(
  parameter int W        = 6,
  parameter bit SATURATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         at_end
);

  generate
    if (SATURATE) begin : g_sat
      // Counts steps up to limit and holds there until cleared
      assign at_end = (count >= limit);

      always_ff @(posedge clk) begin
        if (rst || clr)           count <= '0;
        else if (step && !at_end) count <= count + W'(1);
      end

      // R9
      sat_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= limit);
    end else begin : g_wrap
      // Counts steps modulo limit and flags the wrapping step
      assign at_end = step && (count == limit - W'(1));

      always_ff @(posedge clk) begin
        if (rst || clr || at_end) count <= '0;
        else if (step)            count <= count + W'(1);
      end

      // R2
      wrap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (limit != '0) |-> (count < limit));
    end
  endgenerate

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter int NW = 4,
  parameter int PW = 6,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] cfg_n,
  input  logic [PW-1:0] cfg_p,
  input  logic [SW-1:0] cfg_s,
  output logic          div_pulse
);

  logic [NW-1:0] n_q;
  logic [PW-1:0] p_q;
  logic [SW-1:0] s_q;
  logic          pre_tick;
  logic          period_end;
  logic          swallow_done;
  logic [PW-1:0] prog_count;
  logic [SW-1:0] swal_count;
  ps_mode_e      mode;

  psd_cfg_hold #(.NW(NW), .PW(PW), .SW(SW)) i_cfg (
    .clk  (clk),
    .rst  (rst),
    .load (period_end),
    .n_in (cfg_n),
    .p_in (cfg_p),
    .s_in (cfg_s),
    .n_q  (n_q),
    .p_q  (p_q),
    .s_q  (s_q)
  );

  assign mode = swallow_done ? PS_DIV_N : PS_DIV_N1;

  psd_prescaler #(.NW(NW)) i_presc (
    .clk   (clk),
    .rst   (rst),
    .div_n (n_q),
    .mode  (mode),
    .tick  (pre_tick)
  );

  // Program counter: wraps after P prescaler ticks and ends the period
  psd_event_ctr #(.W(PW), .SATURATE(1'b0)) i_prog (
    .clk    (clk),
    .rst    (rst),
    .step   (pre_tick),
    .clr    (1'b0),
    .limit  (p_q),
    .count  (prog_count),
    .at_end (period_end)
  );

  // Swallow counter: saturates at S, cleared at period end (clear wins)
  psd_event_ctr #(.W(SW), .SATURATE(1'b1)) i_swal (
    .clk    (clk),
    .rst    (rst),
    .step   (pre_tick),
    .clr    (period_end),
    .limit  (s_q),
    .count  (swal_count),
    .at_end (swallow_done)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= period_end;
  end

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && (n_q >= NW'(2))) |=> !div_pulse);

  // R5
  period_start_chk: assert property (@(posedge clk) disable iff (rst)
    period_end |=> ((prog_count == '0) && (swal_count == '0) &&
                    ((mode == PS_DIV_N1) || (s_q == '0))));

endmodule

// File: tb/test_pulse_swallow_divider.sv
`timescale 1ns/1ps
module test_pulse_swallow_divider;

  localparam int NW = 4;
  localparam int PW = 6;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] cfg_n = '0;
  logic [PW-1:0] cfg_p = '0;
  logic [SW-1:0] cfg_s = '0;
  logic          div_pulse;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pulse_swallow_divider #(.NW(NW), .PW(PW), .SW(SW)) i_pulse_swallow_divider (
    .clk       (clk),
    .rst       (rst),
    .cfg_n     (cfg_n),
    .cfg_p     (cfg_p),
    .cfg_s     (cfg_s),
    .div_pulse (div_pulse)
  );

  function automatic int ratio(int n, int p, int s);
    return (s < p) ? (n * p + s) : ((n + 1) * p);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int n, int p, int s);
    cfg_n = NW'(n);
    cfg_p = PW'(p);
    cfg_s = SW'(s);
  endtask

  // Counts negedges until div_pulse is seen high
  task automatic wait_pulse(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!div_pulse && cyc < 2000);
  endtask

  // Reset with a configuration, then check first period, width, second period
  task automatic run_case(int n, int p, int s, string tag);
    int c;
    int exp;
    exp = ratio(n, p, s);
    rst = 1'b1;
    set_cfg(n, p, s);
    repeat (2) @(negedge clk);
    check("R1 reset output", int'(div_pulse), 0);
    rst = 1'b0;
    wait_pulse(c);
    check("R3 first pulse", c, exp);
    @(negedge clk);
    check("R4 pulse width", int'(div_pulse), 0);
    wait_pulse(c);
    check(tag, c + 1, exp);
  endtask

  initial begin
    #750us;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int c;
    // R2 / R5 / R8 / R9: near-exhaustive sweep of small legal configurations
    for (int n = 2; n <= 5; n++) begin
      for (int p = 1; p <= 6; p++) begin
        for (int s = 0; s < p; s++) begin
          run_case(n, p, s, (s == 0) ? "R5 period S=0" : "R2 period");
        end
      end
    end

    // R7: swallow limit reaches or exceeds program length
    run_case(3, 3, 3, "R7 period S=P");
    run_case(3, 3, 5, "R7 period S>P");
    run_case(2, 1, 4, "R7 period P=1");
    run_case(5, 4, 9, "R7 period S>>P");

    // R6: pins change just after a pulse, then in the middle of a period
    rst = 1'b1;
    set_cfg(3, 4, 1);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wait_pulse(c);
    check("R6 first A", c, 13);
    set_cfg(4, 3, 2);
    wait_pulse(c);
    check("R6 old length kept", c, 13);
    wait_pulse(c);
    check("R6 new length B", c, 14);
    repeat (4) @(negedge clk);
    set_cfg(2, 5, 0);
    wait_pulse(c);
    check("R6 mid-period change", c + 4, 14);
    wait_pulse(c);
    check("R6 new length C", c, 10);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule